// File: doc/BRIEF.md
# Dual-Issue Register Transfer Unit

This block holds a small file of edge-triggered working registers and changes them one clock at a time by register-transfer microoperations. Each cycle, up to two issue slots may each name an operation, two source registers and one destination register. Every enabled slot reads the register values as they stood before the clock edge. Its result is written to its destination at that edge. Two slots can therefore exchange registers, or update unrelated registers together, in a single cycle.

The operation set has four classes. The first is any of the sixteen two-input bitwise functions. The second is an arithmetic group: add, subtract, increment and two's-complement negate. The third is a group of shifts: logical and rotate in both directions, plus sign-aware shifts. The fourth is a plain register move. The block keeps an overflow flag and a carry flag, and each flag is written only by the operations it belongs to. When both slots aim at the same destination in one cycle, the request is illegal. The block then writes neither slot, leaves that register untouched and raises an error indication for one cycle.

A global load enable gates all state changes. There is no external data path: register contents are built up from reset with the operations themselves.

Top module: `microop_unit`

## Requirements
- R1: A synchronous reset clears every register, both flags and the error indication to 0 at the next rising edge.
- R2: While `loadEn` is low, registers and flags hold whatever the slot inputs are, and `conflictErr` reads 0 after that edge.
- R3: An opcode `{2'b00, n}` writes the bitwise function whose result bit for operands (x, y) is bit `{~x, ~y}` of n. So n = 0 gives all zeros, n = 1 AND, n = 6 XOR, n = 7 OR, n = 8 NOR, n = 12 NOT x, n = 14 NAND and n = 15 all ones.
- R4: Opcode 0x10 writes x + y and opcode 0x11 writes x - y (computed as x + ~y + 1), both modulo 256. The carry flag takes the carry out, which for subtraction is 1 exactly when x >= y unsigned.
- R5: Opcode 0x12 writes x + 1, so 0xFF wraps to 0x00, and opcode 0x13 writes the two's-complement negation 0 - x.
- R6: For opcodes 0x10 to 0x13 the overflow flag is set when the signed result does not fit in 8 bits, such as 0x7F + 1 or negating 0x80. It is cleared otherwise.
- R7: Opcodes 0x20/0x21 shift x left/right with a 0 entering, and opcodes 0x22/0x23 rotate x left/right. These four write overflow 0.
- R8: Opcode 0x24 shifts left with a 0 into bit 0 and sets overflow when bit 7 changes (0x9C gives 0x38 with overflow 1). Opcode 0x25 shifts right copying bit 7 (0x9C gives 0xCE) and writes overflow 0.
- R9: The overflow flag updates only when a committing slot runs an arithmetic or shift opcode, and the carry flag only on add or subtract. When both slots update a flag, it takes the OR of their results.
- R10: With two enabled slots on different destinations, both results are written at the same edge and both read pre-edge values, so two crossed moves exchange registers.
- R11: If both slots are enabled on the same destination with `loadEn` high, that register and the flags keep their values, and `conflictErr` is 1 after the edge.
- R12: Opcode 0x30 copies x to the destination and leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | Global enable for all register and flag writes |
| slotEn | input | 2 | Per-slot issue enable, bit s for slot s |
| slotOp | input | 12 | Opcodes, slot s in bits [6s+5:6s] |
| slotSrcX | input | 4 | First source register index, slot s in bits [2s+1:2s] |
| slotSrcY | input | 4 | Second source register index, slot s in bits [2s+1:2s] |
| slotDst | input | 4 | Destination register index, slot s in bits [2s+1:2s] |
| regBus | output | 32 | Register r contents in bits [8r+7:8r] |
| ovfFlag | output | 1 | Signed overflow flag |
| carryFlag | output | 1 | Carry out of the last add or subtract |
| conflictErr | output | 1 | Same-destination conflict seen at the last edge |

## Verification
Every register is visible on `regBus`, so a wrong operand pick, result or write strobe appears at the ports one edge after the offending cycle, and the bench compares all registers after every step. A flag that is written when it should hold, or held when it should be written, shows up in the same cycle. Such errors tend to linger, because later logic and move operations leave the stale value visible until the next arithmetic or shift. A conflict handled wrongly shows as a changed destination or a missing error pulse one edge later.

// File: rtl/microop_pkg.sv
package microop_pkg;

  localparam int SLOTS = 2;
  localparam int OP_W  = 6;

  typedef enum logic [1:0] {
    CLS_LOGIC = 2'b00,
    CLS_ARITH = 2'b01,
    CLS_SHIFT = 2'b10,
    CLS_MOVE  = 2'b11
  } opClass_e;

  typedef enum logic [1:0] {
    AK_ADD = 2'b00,
    AK_SUB = 2'b01,
    AK_INC = 2'b10,
    AK_NEG = 2'b11
  } arithKind_e;

  // Control-to-datapath strobes, one bit per issue slot.
  typedef struct packed {
    logic [SLOTS-1:0] commit;
    logic [SLOTS-1:0] ovfUpd;
    logic [SLOTS-1:0] carryUpd;
  } strobe_t;

endpackage

// File: rtl/microop_exec.sv
module microop_exec import microop_pkg::*; #(
  parameter int WIDTH = 8
) (
  input  logic [OP_W-1:0]  op,
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] res,
  output logic             ovf,
  output logic             carry
);

  localparam int MSB = WIDTH - 1;

  // Bitwise section: the function code is a truth table indexed per bit.
  logic [3:0]       funcCode;
  logic [WIDTH-1:0] logicRes;
  assign funcCode = op[3:0];

  for (genvar b = 0; b < WIDTH; b++) begin : g_lut
    assign logicRes[b] = funcCode[{~x[b], ~y[b]}];
  end

  // Arithmetic section: one adder, operands steered per kind.
  logic [WIDTH-1:0] addA, addB;
  logic             addCin;
  logic [WIDTH:0]   sum;
  logic             arithOvf;

  always_comb begin
    unique case (arithKind_e'(op[1:0]))
      AK_ADD:  begin addA = x;        addB = y;        addCin = 1'b0; end
      AK_SUB:  begin addA = x;        addB = ~y;       addCin = 1'b1; end
      AK_INC:  begin addA = x;        addB = '0;       addCin = 1'b1; end
      default: begin addA = '0;       addB = ~x;       addCin = 1'b1; end
    endcase
    sum      = {1'b0, addA} + {1'b0, addB} + (WIDTH+1)'(addCin);
    arithOvf = (addA[MSB] == addB[MSB]) && (sum[MSB] != addA[MSB]);
  end

  // Shift section: op[2] picks sign-aware, op[1] rotate, op[0] right.
  logic [WIDTH-1:0] shiftRes;
  logic             shiftOvf;

  always_comb begin
    shiftOvf = 1'b0;
    if (op[2]) begin
      if (op[0]) begin
        shiftRes = {x[MSB], x[MSB:1]};
      end else begin
        shiftRes = {x[MSB-1:0], 1'b0};
        shiftOvf = x[MSB] ^ x[MSB-1];
      end
    end else if (op[1]) begin
      shiftRes = op[0] ? {x[0], x[MSB:1]} : {x[MSB-1:0], x[MSB]};
    end else begin
      shiftRes = op[0] ? {1'b0, x[MSB:1]} : {x[MSB-1:0], 1'b0};
    end
  end

  always_comb begin
    ovf   = 1'b0;
    carry = 1'b0;
    unique case (opClass_e'(op[5:4]))
      CLS_LOGIC: res = logicRes;
      CLS_ARITH: begin
        res   = sum[MSB:0];
        ovf   = arithOvf;
        carry = sum[WIDTH];
      end
      CLS_SHIFT: begin
        res = shiftRes;
        ovf = shiftOvf;
      end
      default:   res = x;
    endcase
  end

  // Right sign-aware shift never reports overflow.
  always_comb begin
    if (op[5:4] == CLS_SHIFT && op[2] && op[0]) begin
      p_ashr_no_ovf_r8: assert (!ovf);
    end
  end

endmodule

// File: rtl/microop_ctrl.sv
module microop_ctrl import microop_pkg::*; #(
  parameter int IDX_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   loadEn,
  input  logic [SLOTS-1:0]       slotEn,
  input  logic [2*SLOTS-1:0]     slotCls,
  input  logic [SLOTS-1:0]       slotIncNeg,
  input  logic [SLOTS*IDX_W-1:0] slotDst,
  output strobe_t                strobes,
  output logic                   conflictErr
);

  // A slot clashes when any other enabled slot names the same destination.
  logic [SLOTS-1:0] clash;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      clash[i] = 1'b0;
      for (int j = 0; j < SLOTS; j++) begin
        if (j != i && slotEn[j] &&
            slotDst[j*IDX_W +: IDX_W] == slotDst[i*IDX_W +: IDX_W]) begin
          clash[i] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    logic commitV;
    logic isArith;
    logic isShift;
    strobes = '0;
    for (int i = 0; i < SLOTS; i++) begin
      commitV = loadEn && slotEn[i] && !clash[i];
      isArith = (slotCls[2*i +: 2] == CLS_ARITH);
      isShift = (slotCls[2*i +: 2] == CLS_SHIFT);
      strobes.commit[i]   = commitV;
      strobes.ovfUpd[i]   = commitV && (isArith || isShift);
      strobes.carryUpd[i] = commitV && isArith && !slotIncNeg[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) conflictErr <= 1'b0;
    else     conflictErr <= loadEn && |(slotEn & clash);
  end

  p_err_on_clash_r11: assert property (@(posedge clk) disable iff (rst)
    (loadEn && slotEn[0] && slotEn[1] &&
     slotDst[IDX_W-1:0] == slotDst[2*IDX_W-1:IDX_W]) |=> conflictErr);

  p_err_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !loadEn |=> !conflictErr);

endmodule

// File: rtl/microop_dp.sv
module microop_dp import microop_pkg::*; #(
  parameter int WIDTH    = 8,
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  strobe_t                   strobes,
  input  logic [SLOTS*OP_W-1:0]     slotOp,
  input  logic [SLOTS*IDX_W-1:0]    slotSrcX,
  input  logic [SLOTS*IDX_W-1:0]    slotSrcY,
  input  logic [SLOTS*IDX_W-1:0]    slotDst,
  output logic [NUM_REGS*WIDTH-1:0] regBus,
  output logic                      ovfFlag,
  output logic                      carryFlag
);

  logic [WIDTH-1:0] regs  [NUM_REGS];
  logic [WIDTH-1:0] opX   [SLOTS];
  logic [WIDTH-1:0] opY   [SLOTS];
  logic [WIDTH-1:0] res   [SLOTS];
  logic [SLOTS-1:0] slotOvf;
  logic [SLOTS-1:0] slotCarry;
  logic [SLOTS-1:0] hit   [NUM_REGS];

  // Operand fetch reads pre-edge register values.
  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      opX[s] = regs[slotSrcX[s*IDX_W +: IDX_W]];
      opY[s] = regs[slotSrcY[s*IDX_W +: IDX_W]];
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    microop_exec #(.WIDTH(WIDTH)) u_exec (
      .op    (slotOp[s*OP_W +: OP_W]),
      .x     (opX[s]),
      .y     (opY[s]),
      .res   (res[s]),
      .ovf   (slotOvf[s]),
      .carry (slotCarry[s])
    );
  end

  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      for (int s = 0; s < SLOTS; s++) begin
        hit[r][s] = strobes.commit[s] &&
                    (slotDst[s*IDX_W +: IDX_W] == IDX_W'(r));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) regs[r] <= '0;
      ovfFlag   <= 1'b0;
      carryFlag <= 1'b0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        for (int s = 0; s < SLOTS; s++) begin
          if (hit[r][s]) regs[r] <= res[s];
        end
      end
      if (|strobes.ovfUpd)   ovfFlag   <= |(strobes.ovfUpd & slotOvf);
      if (|strobes.carryUpd) carryFlag <= |(strobes.carryUpd & slotCarry);
    end
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_regout
    assign regBus[r*WIDTH +: WIDTH] = regs[r];

    p_one_writer_r11: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hit[r]));

    p_reg_hold_r11: assert property (@(posedge clk) disable iff (rst)
      !(|hit[r]) |=> $stable(regBus[r*WIDTH +: WIDTH]));
  end

  p_ovf_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(|strobes.ovfUpd) |=> $stable(ovfFlag));

  p_carry_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(|strobes.carryUpd) |=> $stable(carryFlag));

endmodule

// File: rtl/microop_unit.sv
module microop_unit import microop_pkg::*; #(
  parameter int WIDTH    = 8,
  parameter int NUM_REGS = 4
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     loadEn,
  input  logic [SLOTS-1:0]                         slotEn,
  input  logic [SLOTS*OP_W-1:0]                    slotOp,
  input  logic [SLOTS*$clog2(NUM_REGS)-1:0]        slotSrcX,
  input  logic [SLOTS*$clog2(NUM_REGS)-1:0]        slotSrcY,
  input  logic [SLOTS*$clog2(NUM_REGS)-1:0]        slotDst,
  output logic [NUM_REGS*WIDTH-1:0]                regBus,
  output logic                                     ovfFlag,
  output logic                                     carryFlag,
  output logic                                     conflictErr
);

  localparam int IDX_W = $clog2(NUM_REGS);

  strobe_t            strobes;
  logic [2*SLOTS-1:0] slotCls;
  logic [SLOTS-1:0]   slotIncNeg;

  for (genvar s = 0; s < SLOTS; s++) begin : g_dec
    assign slotCls[2*s +: 2] = slotOp[s*OP_W + 4 +: 2];
    assign slotIncNeg[s]     = slotOp[s*OP_W + 1];
  end

  microop_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .loadEn      (loadEn),
    .slotEn      (slotEn),
    .slotCls     (slotCls),
    .slotIncNeg  (slotIncNeg),
    .slotDst     (slotDst),
    .strobes     (strobes),
    .conflictErr (conflictErr)
  );

  microop_dp #(.WIDTH(WIDTH), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .slotOp    (slotOp),
    .slotSrcX  (slotSrcX),
    .slotSrcY  (slotSrcY),
    .slotDst   (slotDst),
    .regBus    (regBus),
    .ovfFlag   (ovfFlag),
    .carryFlag (carryFlag)
  );

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !loadEn |=> ($stable(regBus) && $stable(ovfFlag) && $stable(carryFlag)));

endmodule

// File: tb/tb_microop_unit.sv
module tb_microop_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        loadEn;
  logic [1:0]  slotEn;
  logic [11:0] slotOp;
  logic [3:0]  slotSrcX, slotSrcY, slotDst;
  logic [31:0] regBus;
  logic        ovfFlag, carryFlag, conflictErr;

  always #5 clk = ~clk;

  microop_unit dut (
    .clk(clk), .rst(rst), .loadEn(loadEn), .slotEn(slotEn), .slotOp(slotOp),
    .slotSrcX(slotSrcX), .slotSrcY(slotSrcY), .slotDst(slotDst),
    .regBus(regBus), .ovfFlag(ovfFlag), .carryFlag(carryFlag),
    .conflictErr(conflictErr)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [7:0] mReg [4];
  logic       mOvf, mCarry, mErr;

  // Reference result: {ovf, carry, result}
  function automatic logic [9:0] refOp(input logic [5:0] op,
                                       input logic [7:0] x, input logic [7:0] y);
    logic [7:0] r;
    logic v, c;
    int sx, sy, t;
    v = 1'b0; c = 1'b0;
    sx = $signed(x); sy = $signed(y);
    case (op[5:4])
      2'b00: case (op[3:0])
        4'd0: r = 8'h00;       4'd1: r = x & y;
        4'd2: r = x & ~y;      4'd3: r = x;
        4'd4: r = ~x & y;      4'd5: r = y;
        4'd6: r = x ^ y;       4'd7: r = x | y;
        4'd8: r = ~(x | y);    4'd9: r = ~(x ^ y);
        4'd10: r = ~y;         4'd11: r = x | ~y;
        4'd12: r = ~x;         4'd13: r = ~x | y;
        4'd14: r = ~(x & y);   default: r = 8'hFF;
      endcase
      2'b01: case (op[1:0])
        2'd0: begin r = x + y; c = ({1'b0, x} + {1'b0, y}) > 9'd255;
                    t = sx + sy; v = (t > 127) || (t < -128); end
        2'd1: begin r = x - y; c = (x >= y);
                    t = sx - sy; v = (t > 127) || (t < -128); end
        2'd2: begin r = x + 8'd1; v = (x == 8'h7F); end
        default: begin r = 8'd0 - x; v = (x == 8'h80); end
      endcase
      2'b10: begin
        if (op[2]) begin
          if (op[0]) r = {x[7], x[7:1]};
          else begin r = x << 1; v = (x[7] != x[6]); end
        end else if (op[1]) r = op[0] ? {x[0], x[7:1]} : {x[6:0], x[7]};
        else r = op[0] ? (x >> 1) : (x << 1);
      end
      default: r = x;
    endcase
    return {v, c, r};
  endfunction

  function automatic string tagOf(input logic [5:0] op);
    case (op[5:4])
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic compareAll(input string tag);
    logic [31:0] expBus;
    expBus = {mReg[3], mReg[2], mReg[1], mReg[0]};
    nChecks++;
    if (regBus !== expBus || ovfFlag !== mOvf || carryFlag !== mCarry ||
        conflictErr !== mErr) begin
      nFails++;
      $display("FAIL %s: actual regs=%h ovf=%b carry=%b err=%b expected regs=%h ovf=%b carry=%b err=%b",
               tag, regBus, ovfFlag, carryFlag, conflictErr,
               expBus, mOvf, mCarry, mErr);
    end
  endtask

  task automatic step(input string tag, input bit le, input bit [1:0] en,
                      input bit [5:0] op0, input bit [1:0] x0, input bit [1:0] y0,
                      input bit [1:0] d0,
                      input bit [5:0] op1, input bit [1:0] x1, input bit [1:0] y1,
                      input bit [1:0] d1);
    logic [7:0] nReg [4];
    logic [9:0] r;
    bit [5:0] ops [2];
    bit [1:0] xs [2], ys [2], ds [2];
    bit clashV, ovfU, ovfV, carU, carV;
    @(negedge clk);
    loadEn = le; slotEn = en; slotOp = {op1, op0};
    slotSrcX = {x1, x0}; slotSrcY = {y1, y0}; slotDst = {d1, d0};
    ops[0] = op0; ops[1] = op1; xs[0] = x0; xs[1] = x1;
    ys[0] = y0; ys[1] = y1; ds[0] = d0; ds[1] = d1;
    for (int i = 0; i < 4; i++) nReg[i] = mReg[i];
    clashV = en[0] && en[1] && (d0 == d1);
    if (!le) mErr = 1'b0;
    else begin
      mErr = clashV;
      ovfU = 0; ovfV = 0; carU = 0; carV = 0;
      for (int s = 0; s < 2; s++) begin
        if (en[s] && !clashV) begin
          r = refOp(ops[s], mReg[xs[s]], mReg[ys[s]]);
          nReg[ds[s]] = r[7:0];
          if (ops[s][5:4] == 2'b01 || ops[s][5:4] == 2'b10) begin
            ovfU = 1; ovfV = ovfV | r[9];
          end
          if (ops[s][5:4] == 2'b01 && !ops[s][1]) begin
            carU = 1; carV = carV | r[8];
          end
        end
      end
      for (int i = 0; i < 4; i++) mReg[i] = nReg[i];
      if (ovfU) mOvf = ovfV;
      if (carU) mCarry = carV;
    end
    @(posedge clk);
    #2;
    compareAll(tag);
  endtask

  task automatic one(input string tag, input bit [5:0] op, input bit [1:0] x,
                     input bit [1:0] y, input bit [1:0] d);
    step(tag, 1'b1, 2'b01, op, x, y, d, 6'h00, 2'd0, 2'd0, 2'd0);
  endtask

  // Builds a value from zero with clear, shift-left and increment.
  task automatic loadVal(input bit [1:0] d, input bit [7:0] v);
    one("R3", 6'h00, d, d, d);
    for (int b = 7; b >= 0; b--) begin
      one("R7", 6'h20, d, d, d);
      if (v[b]) one("R5", 6'h12, d, d, d);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; loadEn = 1'b0; slotEn = '0; slotOp = '0;
    slotSrcX = '0; slotSrcY = '0; slotDst = '0;
    for (int i = 0; i < 4; i++) mReg[i] = 8'h00;
    mOvf = 0; mCarry = 0; mErr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compareAll("R1");

    loadVal(2'd0, 8'hF2); loadVal(2'd1, 8'hFF);
    loadVal(2'd2, 8'hB9); loadVal(2'd3, 8'hEA);
    one("R4", 6'h10, 2'd0, 2'd1, 2'd0);                 // F2+FF -> F1, carry
    step("R10", 1'b1, 2'b11, 6'h01, 2'd2, 2'd3, 2'd2,   // CR&DR, BR+1 together
         6'h12, 2'd1, 2'd1, 2'd1);
    one("R4", 6'h11, 2'd0, 2'd2, 2'd0);                 // F1-A8 -> 49

    loadVal(2'd3, 8'h9C);
    one("R8", 6'h25, 2'd3, 2'd3, 2'd2);                 // -> CE, ovf 0
    one("R8", 6'h24, 2'd3, 2'd3, 2'd2);                 // -> 38, ovf 1
    one("R9", 6'h03, 2'd0, 2'd0, 2'd1);                 // logic: flags hold
    one("R12", 6'h30, 2'd3, 2'd3, 2'd1);                // move, flags hold

    loadVal(2'd2, 8'hDD);
    one("R7", 6'h20, 2'd2, 2'd2, 2'd2);                 // BA
    one("R7", 6'h23, 2'd2, 2'd2, 2'd2);                 // 5D
    one("R7", 6'h21, 2'd2, 2'd2, 2'd2);                 // 2E
    one("R7", 6'h22, 2'd2, 2'd2, 2'd2);                 // 5C

    loadVal(2'd1, 8'h7F);
    one("R6", 6'h12, 2'd1, 2'd1, 2'd1);                 // 80, ovf 1
    one("R6", 6'h13, 2'd1, 2'd1, 2'd3);                 // neg 80, ovf 1
    one("R5", 6'h0F, 2'd1, 2'd1, 2'd1);                 // FF
    one("R5", 6'h12, 2'd1, 2'd1, 2'd1);                 // wraps to 00
    one("R5", 6'h13, 2'd0, 2'd0, 2'd0);                 // negate

    step("R10", 1'b1, 2'b11, 6'h30, 2'd1, 2'd1, 2'd0,   // exchange AR, BR
         6'h30, 2'd0, 2'd0, 2'd1);
    step("R9", 1'b1, 2'b11, 6'h10, 2'd2, 2'd2, 2'd3,    // two flag writers
         6'h24, 2'd3, 2'd3, 2'd0);
    step("R11", 1'b1, 2'b11, 6'h00, 2'd2, 2'd2, 2'd2,   // clear vs complement
         6'h0C, 2'd2, 2'd2, 2'd2);
    step("R11", 1'b1, 2'b11, 6'h10, 2'd3, 2'd3, 2'd3,   // add vs sub, flags hold
         6'h11, 2'd0, 2'd1, 2'd3);
    for (int k = 0; k < 4; k++)
      step("R2", 1'b0, 2'($urandom), 6'($urandom), 2'($urandom), 2'($urandom),
           2'($urandom), 6'($urandom), 2'($urandom), 2'($urandom), 2'($urandom));

    loadVal(2'd0, 8'h3C); loadVal(2'd1, 8'h5A);
    for (int n = 0; n < 16; n++)
      one("R3", {2'b00, 4'(n)}, 2'd0, 2'd1, 2'd2);

    for (int k = 0; k < 500; k++) begin
      bit [5:0] o0;
      o0 = 6'($urandom);
      step(tagOf(o0), ($urandom % 10) != 0, 2'($urandom), o0,
           2'($urandom), 2'($urandom), 2'($urandom), 6'($urandom),
           2'($urandom), 2'($urandom), 2'($urandom));
    end

    @(negedge clk);
    rst = 1'b1; loadEn = 1'b1; slotEn = 2'b11;
    @(posedge clk);
    #2;
    for (int i = 0; i < 4; i++) mReg[i] = 8'h00;
    mOvf = 0; mCarry = 0; mErr = 0;
    compareAll("R1");
    @(negedge clk);
    rst = 1'b0; loadEn = 1'b0;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule